// File: doc/BRIEF.md
# MMU Control Register Access Unit

This block is the register front end of a paged memory-management unit. A CPU reaches the unit's control registers through a read port and a write port. The registers are the translation-entry data word, the translation-entry tag word, the entry index, the current address-space ID, the zone protection word and the search trigger. Behind the two entry registers sit three arrays, each indexed by the entry index: a data array, a tag array and a narrow address-space-ID array. A read of the tag word brings the stored space ID back into the space-ID register. A write of the tag word files the current space ID beside it.

Two elaboration parameters, the MMU mode and the register access level, decide which accesses take effect. When the MMU is configured out, nothing is visible and nothing is flagged. When the MMU is present, a weak access level hides some registers from reads and protects others from writes. Each refused access of this kind raises a one-cycle illegal-access flag. Writes that change the space ID or the zone word pulse a strobe, so that cached translations can be flushed. The associative search hardware sits outside this block. A search write drives a request and a key, and the block captures the external hit flag and index in the same cycle.

Top module: `mmu_sreg_access`

## Requirements
- R1: After reset, the index, space-ID, zone and the two spare registers read as 0, and the illegal flag, both change strobes and read-valid are low.
- R2: A read request asserts rd_valid exactly one cycle later. rd_data then holds the value the register had before that clock edge.
- R3: When MMU_MODE < 2 or ACCESS_LVL == 0, every read returns 0 and every write has no effect. No illegal flag, strobe or search request is raised.
- R4: Reads of address 0 (entry data), 1 (entry tag), 3 (space ID) and 4 (zone) need bit 0 of ACCESS_LVL. Without it the read returns 0 and illegal is high in the read-valid cycle.
- R5: Writes to address 3 (space ID), 4 (zone) and 5 (search) need ACCESS_LVL > 1. Without it the write leaves all state unchanged and illegal pulses one cycle later.
- R6: A write to address 0 or 1 stores the word in the data or tag array at the low $clog2(ENTRIES) bits of the index register. A read of address 0 or 1 returns that array's entry, with address bit 0 selecting the array.
- R7: A write to address 1 also stores the current low TID_W bits of the space ID into the space-ID array at the same index. A legal read of address 1 loads the space-ID register from that array entry.
- R8: A legal write to address 3 whose low TID_W bits differ from the stored space ID pulses pid_change for one cycle after the edge. A legal write to address 4 with a new value pulses zone_flush the same way. Equal values pulse neither.
- R9: A legal write to address 5 drives srch_en high with srch_key equal to wr_data in the same cycle. On srch_hit the index becomes the zero-extended srch_idx. On a miss, index bit DATA_W-1 is set and its other bits are kept.
- R10: Reset leaves the three arrays unchanged.
- R11: Addresses 2, 6 and 7 store and return any written word at any non-gated access level. Address 5 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | 3 | Register address to read |
| rd_data | output | DATA_W | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result present (one cycle after rd_en) |
| wr_en | input | 1 | Write request |
| wr_addr | input | 3 | Register address to write |
| wr_data | input | DATA_W | Write value |
| illegal | output | 1 | A refused read or write occurred the previous cycle |
| pid_change | output | 1 | Space ID was changed by the previous write |
| zone_flush | output | 1 | Zone word was changed by the previous write |
| srch_en | output | 1 | Search request to the external lookup |
| srch_key | output | DATA_W | Search key |
| srch_hit | input | 1 | External lookup matched |
| srch_idx | input | $clog2(ENTRIES) | Matching entry index |

## Verification
A wrong index register shows up on the very next entry read. The data or tag returned comes from the wrong slot, and a tag read then loads the space-ID register with a foreign ID, so a following space-ID read exposes it too. A stale space-ID register or a corrupted space-ID array shows one read later. A permission decision that is wrong reaches the ports in a single cycle, as a spurious or missing illegal pulse, a non-zero read under a refused level, or a strobe on a write that should have been dropped. The bench runs four parameter sets side by side so that each threshold is seen from both sides.

// File: rtl/mmu_sreg_pkg.sv
package mmu_sreg_pkg;

    typedef enum logic [2:0] {
        RA_ENTRY_LO = 3'd0,
        RA_ENTRY_HI = 3'd1,
        RA_INDEX    = 3'd2,
        RA_SPACE    = 3'd3,
        RA_ZONE     = 3'd4,
        RA_SEARCH   = 3'd5,
        RA_SPARE0   = 3'd6,
        RA_SPARE1   = 3'd7
    } reg_addr_e;

    // Registers whose reads need the low access-level bit.
    function automatic logic read_is_guarded(input logic [2:0] a);
        return (a == RA_ENTRY_LO) || (a == RA_ENTRY_HI) ||
               (a == RA_SPACE)    || (a == RA_ZONE);
    endfunction

    // Registers whose writes need the full access level.
    function automatic logic write_is_guarded(input logic [2:0] a);
        return (a == RA_SPACE) || (a == RA_ZONE) || (a == RA_SEARCH);
    endfunction

endpackage

// File: rtl/mmu_sreg_policy.sv
module mmu_sreg_policy
    import mmu_sreg_pkg::*;
#(
    parameter int MMU_MODE   = 3,
    parameter int ACCESS_LVL = 3
) (
    input  logic       rd_en,
    input  logic [2:0] rd_addr,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    output logic       rd_ok,
    output logic       rd_bad,
    output logic       wr_ok,
    output logic       wr_bad
);

    localparam bit GATED   = (MMU_MODE < 2) || (ACCESS_LVL == 0);
    localparam bit VIEW_OK = (ACCESS_LVL % 2) == 1;
    localparam bit FULL_OK = ACCESS_LVL > 1;

    logic rd_guard;
    logic wr_guard;

    always_comb begin
        rd_guard = read_is_guarded(rd_addr);
        wr_guard = write_is_guarded(wr_addr);
        rd_ok    = 1'b0;
        rd_bad   = 1'b0;
        wr_ok    = 1'b0;
        wr_bad   = 1'b0;
        if (!GATED) begin
            rd_ok  = rd_en && (!rd_guard || VIEW_OK);
            rd_bad = rd_en && rd_guard && !VIEW_OK;
            wr_ok  = wr_en && (!wr_guard || FULL_OK);
            wr_bad = wr_en && wr_guard && !FULL_OK;
        end
    end

endmodule

// File: rtl/mmu_sreg_ram.sv
module mmu_sreg_ram #(
    parameter int ENTRIES = 256,
    parameter int DATA_W  = 32,
    parameter int TID_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        word_we,
    input  logic [DATA_W-1:0] word_wdata,
    input  logic              tid_we,
    input  logic [TID_W-1:0]  tid_wdata,
    output logic [DATA_W-1:0] word_rdata [2],
    output logic [TID_W-1:0]  tid_rdata
);

    // Arrays are deliberately left without reset.
    genvar h;
    generate
        for (h = 0; h < 2; h++) begin : g_half
            logic [DATA_W-1:0] mem [ENTRIES];

            always_ff @(posedge clk) begin
                if (word_we[h]) begin
                    mem[idx] <= word_wdata;
                end
            end

            assign word_rdata[h] = mem[idx];
        end
    endgenerate

    logic [TID_W-1:0] tid_mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (tid_we) begin
            tid_mem[idx] <= tid_wdata;
        end
    end

    assign tid_rdata = tid_mem[idx];

endmodule

// File: rtl/mmu_sreg_access.sv
module mmu_sreg_access
    import mmu_sreg_pkg::*;
#(
    parameter int MMU_MODE   = 3,
    parameter int ACCESS_LVL = 3,
    parameter int ENTRIES    = 256,
    parameter int DATA_W     = 32,
    parameter int TID_W      = 8,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              illegal,
    output logic              pid_change,
    output logic              zone_flush,
    output logic              srch_en,
    output logic [DATA_W-1:0] srch_key,
    input  logic              srch_hit,
    input  logic [IDX_W-1:0]  srch_idx
);

    typedef struct packed {
        logic [DATA_W-1:0] index;
        logic [TID_W-1:0]  space;
        logic [DATA_W-1:0] zone;
        logic [DATA_W-1:0] spare0;
        logic [DATA_W-1:0] spare1;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              illegal;
        logic              pid_chg;
        logic              zone_fl;
    } state_t;

    state_t st_q;
    state_t st_d;

    logic rd_ok, rd_bad, wr_ok, wr_bad;

    mmu_sreg_policy #(
        .MMU_MODE   (MMU_MODE),
        .ACCESS_LVL (ACCESS_LVL)
    ) u_policy (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_ok   (rd_ok),
        .rd_bad  (rd_bad),
        .wr_ok   (wr_ok),
        .wr_bad  (wr_bad)
    );

    logic [IDX_W-1:0]  ent_idx;
    logic [1:0]        word_we;
    logic              tid_we;
    logic [DATA_W-1:0] word_rdata [2];
    logic [TID_W-1:0]  tid_rdata;

    assign ent_idx = st_q.index[IDX_W-1:0];

    always_comb begin
        word_we[0] = wr_ok && (wr_addr == RA_ENTRY_LO);
        word_we[1] = wr_ok && (wr_addr == RA_ENTRY_HI);
        tid_we     = word_we[1];
    end

    mmu_sreg_ram #(
        .ENTRIES (ENTRIES),
        .DATA_W  (DATA_W),
        .TID_W   (TID_W)
    ) u_ram (
        .clk        (clk),
        .idx        (ent_idx),
        .word_we    (word_we),
        .word_wdata (wr_data),
        .tid_we     (tid_we),
        .tid_wdata  (st_q.space),
        .word_rdata (word_rdata),
        .tid_rdata  (tid_rdata)
    );

    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        unique case (rd_addr)
            RA_ENTRY_LO, RA_ENTRY_HI: rd_mux = word_rdata[rd_addr[0]];
            RA_INDEX:                 rd_mux = st_q.index;
            RA_SPACE:                 rd_mux = {{(DATA_W-TID_W){1'b0}}, st_q.space};
            RA_ZONE:                  rd_mux = st_q.zone;
            RA_SEARCH:                rd_mux = '0;
            RA_SPARE0:                rd_mux = st_q.spare0;
            RA_SPARE1:                rd_mux = st_q.spare1;
            default:                  rd_mux = '0;
        endcase
    end

    assign srch_en  = wr_ok && (wr_addr == RA_SEARCH);
    assign srch_key = wr_data;

    always_comb begin
        st_d         = st_q;
        st_d.rvalid  = rd_en;
        st_d.illegal = rd_bad || wr_bad;
        st_d.pid_chg = 1'b0;
        st_d.zone_fl = 1'b0;

        if (rd_en) begin
            st_d.rdata = rd_ok ? rd_mux : '0;
        end

        // A tag read reloads the space ID; a same-cycle space write overrides it.
        if (rd_ok && (rd_addr == RA_ENTRY_HI)) begin
            st_d.space = tid_rdata;
        end

        if (wr_ok) begin
            unique case (wr_addr)
                RA_INDEX: st_d.index = wr_data;
                RA_SPACE: begin
                    st_d.pid_chg = (wr_data[TID_W-1:0] != st_q.space);
                    st_d.space   = wr_data[TID_W-1:0];
                end
                RA_ZONE: begin
                    st_d.zone_fl = (wr_data != st_q.zone);
                    st_d.zone    = wr_data;
                end
                RA_SEARCH: begin
                    if (srch_hit) begin
                        st_d.index = {{(DATA_W-IDX_W){1'b0}}, srch_idx};
                    end else begin
                        st_d.index[DATA_W-1] = 1'b1;
                    end
                end
                RA_SPARE0: st_d.spare0 = wr_data;
                RA_SPARE1: st_d.spare1 = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = st_q.rdata;
    assign rd_valid   = st_q.rvalid;
    assign illegal    = st_q.illegal;
    assign pid_change = st_q.pid_chg;
    assign zone_flush = st_q.zone_fl;

endmodule

// File: rtl/mmu_sreg_chk.sv
module mmu_sreg_chk
    import mmu_sreg_pkg::*;
#(
    parameter int MMU_MODE   = 3,
    parameter int ACCESS_LVL = 3,
    parameter int DATA_W     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [2:0]        rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              illegal,
    input logic              pid_change,
    input logic              zone_flush,
    input logic              srch_en,
    input logic [DATA_W-1:0] srch_key
);

    localparam bit GATED   = (MMU_MODE < 2) || (ACCESS_LVL == 0);
    localparam bit VIEW_OK = (ACCESS_LVL % 2) == 1;
    localparam bit FULL_OK = ACCESS_LVL > 1;

    assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_gated_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (GATED && rd_valid) |-> (rd_data == '0));

    assert_gated_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        GATED |-> (!illegal && !pid_change && !zone_flush && !srch_en));

    assert_view_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!GATED && !VIEW_OK && rd_en && read_is_guarded(rd_addr))
        |=> (illegal && rd_data == '0));

    assert_write_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!GATED && !FULL_OK && wr_en && write_is_guarded(wr_addr))
        |=> (illegal && !pid_change && !zone_flush));

    assert_pid_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pid_change |-> $past(wr_en && wr_addr == RA_SPACE));

    assert_zone_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zone_flush |-> $past(wr_en && wr_addr == RA_ZONE));

    assert_search_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |-> (wr_en && wr_addr == RA_SEARCH && srch_key == wr_data));

    assert_illegal_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(rd_en || wr_en));

endmodule

bind mmu_sreg_access mmu_sreg_chk #(
    .MMU_MODE   (MMU_MODE),
    .ACCESS_LVL (ACCESS_LVL),
    .DATA_W     (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .illegal    (illegal),
    .pid_change (pid_change),
    .zone_flush (zone_flush),
    .srch_en    (srch_en),
    .srch_key   (srch_key)
);

// File: tb/sim_mmu_sreg_access.sv
module sim_mmu_sreg_access;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int IW = 8;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic [2:0]    rd_addr = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          srch_hit = 1'b0;
    logic [IW-1:0] srch_idx = '0;

    logic [DW-1:0] o_rdata [NI];
    logic          o_rvalid [NI];
    logic          o_ill [NI];
    logic          o_pid [NI];
    logic          o_zone [NI];
    logic          o_sen [NI];
    logic [DW-1:0] o_skey [NI];

    // Captured per instance after the cycle: 0 full, 1 level 1, 2 gated, 3 level 2
    logic [DW-1:0] c_rdata [NI];
    logic          c_rvalid [NI];
    logic          c_ill [NI];
    logic          c_pid [NI];
    logic          c_zone [NI];
    logic          c_sen [NI];
    logic [DW-1:0] c_skey [NI];

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_sreg_access #(.MMU_MODE(3), .ACCESS_LVL(3)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(o_rdata[0]), .rd_valid(o_rvalid[0]), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .illegal(o_ill[0]),
        .pid_change(o_pid[0]), .zone_flush(o_zone[0]), .srch_en(o_sen[0]),
        .srch_key(o_skey[0]), .srch_hit(srch_hit), .srch_idx(srch_idx));

    mmu_sreg_access #(.MMU_MODE(3), .ACCESS_LVL(1)) u1 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(o_rdata[1]), .rd_valid(o_rvalid[1]), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .illegal(o_ill[1]),
        .pid_change(o_pid[1]), .zone_flush(o_zone[1]), .srch_en(o_sen[1]),
        .srch_key(o_skey[1]), .srch_hit(srch_hit), .srch_idx(srch_idx));

    mmu_sreg_access #(.MMU_MODE(1), .ACCESS_LVL(3)) u2 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(o_rdata[2]), .rd_valid(o_rvalid[2]), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .illegal(o_ill[2]),
        .pid_change(o_pid[2]), .zone_flush(o_zone[2]), .srch_en(o_sen[2]),
        .srch_key(o_skey[2]), .srch_hit(srch_hit), .srch_idx(srch_idx));

    mmu_sreg_access #(.MMU_MODE(3), .ACCESS_LVL(2)) u3 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(o_rdata[3]), .rd_valid(o_rvalid[3]), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .illegal(o_ill[3]),
        .pid_change(o_pid[3]), .zone_flush(o_zone[3]), .srch_en(o_sen[3]),
        .srch_key(o_skey[3]), .srch_hit(srch_hit), .srch_idx(srch_idx));

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, sample search outputs before the edge,
    // sample registered outputs at the following negedge.
    task automatic bus(input logic rd, input logic [2:0] ra, input logic wr,
                       input logic [2:0] wa, input logic [DW-1:0] wd,
                       input logic hit = 1'b0, input logic [IW-1:0] hidx = '0);
        rd_en = rd; rd_addr = ra; wr_en = wr; wr_addr = wa; wr_data = wd;
        srch_hit = hit; srch_idx = hidx;
        #1;
        for (int i = 0; i < NI; i++) begin
            c_sen[i] = o_sen[i];
            c_skey[i] = o_skey[i];
        end
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            c_rdata[i] = o_rdata[i];
            c_rvalid[i] = o_rvalid[i];
            c_ill[i] = o_ill[i];
            c_pid[i] = o_pid[i];
            c_zone[i] = o_zone[i];
        end
        rd_en = 1'b0; wr_en = 1'b0; srch_hit = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        bus(1'b0, 3'd0, 1'b1, a, d);
    endtask

    task automatic rd(input logic [2:0] a);
        bus(1'b1, a, 1'b0, 3'd0, '0);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 rd_valid after reset", {31'b0, o_rvalid[0]}, 0);
        chk("R1 illegal after reset", {31'b0, o_ill[0]}, 0);
        chk("R1 strobes after reset", {30'b0, o_pid[0], o_zone[0]}, 0);
        rd(3'd2); chk("R1 index reset", c_rdata[0], 0);
        rd(3'd3); chk("R1 space reset", c_rdata[0], 0);
        rd(3'd4); chk("R1 zone reset", c_rdata[0], 0);
        rd(3'd6); chk("R1 spare reset", c_rdata[0], 0);
    endtask

    task automatic t_latency();
        wr(3'd6, 32'h1111_2222);
        chk("R2 no valid on write cycle", {31'b0, c_rvalid[0]}, 0);
        // Read and overwrite in the same cycle: old value comes back
        bus(1'b1, 3'd6, 1'b1, 3'd6, 32'h3333_4444);
        chk("R2 valid one cycle later", {31'b0, c_rvalid[0]}, 1);
        chk("R2 pre-edge value", c_rdata[0], 32'h1111_2222);
        rd(3'd6); chk("R11 spare0 readback", c_rdata[0], 32'h3333_4444);
    endtask

    task automatic t_entries();
        wr(3'd2, 32'd5);
        wr(3'd0, 32'hA5A5_0001);
        wr(3'd3, 32'h3C);
        chk("R8 space change strobe", {31'b0, c_pid[0]}, 1);
        chk("R5 level1 space write illegal", {31'b0, c_ill[1]}, 1);
        chk("R3 gated no strobe", {31'b0, c_pid[2]}, 0);
        chk("R3 gated no illegal", {31'b0, c_ill[2]}, 0);
        wr(3'd1, 32'h1234_5000);
        wr(3'd2, 32'd9);
        wr(3'd0, 32'h0BAD_F00D);
        wr(3'd3, 32'h77);
        wr(3'd1, 32'h9999_0000);
        wr(3'd3, 32'h00);
        // Back to entry 5
        wr(3'd2, 32'd5);
        rd(3'd0);
        chk("R6 data word at 5", c_rdata[0], 32'hA5A5_0001);
        chk("R4 level2 data read zero", c_rdata[3], 0);
        chk("R4 level2 data read illegal", {31'b0, c_ill[3]}, 1);
        chk("R4 level1 data read legal", {31'b0, c_ill[1]}, 0);
        chk("R3 gated read zero", c_rdata[2], 0);
        rd(3'd1);
        chk("R6 tag word at 5", c_rdata[0], 32'h1234_5000);
        chk("R6 level1 tag word at 5", c_rdata[1], 32'h1234_5000);
        rd(3'd3);
        chk("R7 space reloaded from entry 5", c_rdata[0], 32'h3C);
        chk("R7 level1 space holds stored zero", c_rdata[1], 0);
        wr(3'd2, 32'd9);
        rd(3'd1);
        chk("R6 tag word at 9", c_rdata[0], 32'h9999_0000);
        rd(3'd3);
        chk("R7 space reloaded from entry 9", c_rdata[0], 32'h77);
        rd(3'd0);
        chk("R6 data word at 9", c_rdata[0], 32'h0BAD_F00D);
        wr(3'd3, 32'h77);
        chk("R8 same space no strobe", {31'b0, c_pid[0]}, 0);
        wr(3'd3, 32'h1_77);
        chk("R8 upper bits ignored for strobe", {31'b0, c_pid[0]}, 0);
    endtask

    task automatic t_zone();
        wr(3'd4, 32'hFFFF_0000);
        chk("R8 zone flush", {31'b0, c_zone[0]}, 1);
        chk("R5 level1 zone write illegal", {31'b0, c_ill[1]}, 1);
        chk("R5 level1 no flush", {31'b0, c_zone[1]}, 0);
        wr(3'd4, 32'hFFFF_0000);
        chk("R8 same zone no flush", {31'b0, c_zone[0]}, 0);
        rd(3'd4);
        chk("R8 zone readback", c_rdata[0], 32'hFFFF_0000);
        chk("R5 level1 zone unchanged", c_rdata[1], 0);
        chk("R4 level2 zone read zero", c_rdata[3], 0);
    endtask

    task automatic t_search();
        bus(1'b0, 3'd0, 1'b1, 3'd5, 32'hCAFE_0000, 1'b1, 8'h2A);
        chk("R9 search request", {31'b0, c_sen[0]}, 1);
        chk("R9 search key", c_skey[0], 32'hCAFE_0000);
        chk("R5 level1 no search request", {31'b0, c_sen[1]}, 0);
        chk("R3 gated no search request", {31'b0, c_sen[2]}, 0);
        rd(3'd2);
        chk("R9 hit loads index", c_rdata[0], 32'h2A);
        wr(3'd2, 32'h0000_0107);
        bus(1'b0, 3'd0, 1'b1, 3'd5, 32'h0, 1'b0, 8'h55);
        chk("R5 level1 search illegal", {31'b0, c_ill[1]}, 1);
        rd(3'd2);
        chk("R9 miss sets top bit", c_rdata[0], 32'h8000_0107);
        chk("R5 level1 index untouched by search", c_rdata[1], 32'h0000_0107);
        chk("R3 gated index stays zero", c_rdata[2], 0);
        rd(3'd5);
        chk("R11 search address reads zero", c_rdata[0], 0);
    endtask

    task automatic t_spare();
        wr(3'd7, 32'hDEAD_BEEF);
        rd(3'd7);
        chk("R11 spare1 readback", c_rdata[0], 32'hDEAD_BEEF);
        chk("R11 spare1 level1 readback", c_rdata[1], 32'hDEAD_BEEF);
        chk("R3 gated spare1 zero", c_rdata[2], 0);
    endtask

    task automatic t_retain();
        apply_reset();
        rd(3'd2);
        chk("R1 index cleared again", c_rdata[0], 0);
        wr(3'd2, 32'd5);
        rd(3'd0);
        chk("R10 data array kept over reset", c_rdata[0], 32'hA5A5_0001);
        rd(3'd1);
        chk("R10 tag array kept over reset", c_rdata[0], 32'h1234_5000);
        rd(3'd3);
        chk("R10 space array kept over reset", c_rdata[0], 32'h3C);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        apply_reset();
        t_reset();
        t_latency();
        t_entries();
        t_zone();
        t_search();
        t_spare();
        t_retain();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule